// File: doc/BRIEF.md
# Data Rate Search Controller

This block chooses the PLL divider modulus and the VCO band for a serial-video reclocker. It works in one of two ways. In manual operation, a two-bit rate select code supplied from outside fixes the divider setting. In automatic operation, the block looks for the right setting by stepping an internal rate code each time the frequency acquisition logic reports that a full sweep ended without lock. It then returns the code it is using on the same two select pins, which turn into outputs.

A standards bit picks one of two decode tables that turn a rate code into a modulus and a band. When the data-present flag drops, the search code freezes. When data returns, acquisition starts again from the setting that was last in use, so a source switch at the same rate locks quickly. The mode, standards and manual select inputs are registered, so any change on them is seen at the next clock edge.

Top module: `rate_search_ctrl`

## Requirements
- R1: After reset, the rate code is 00, the modulus is 4, the band output is high (1), and the select output enable is 0.
- R2: In manual mode (auto_mode_i = 0), the active code equals rate_sel_i as sampled at the previous clock edge, and rate_code_oe_o is 0.
- R3: With the standards bit at 1, the codes decode as follows, written as code, modulus, band_hi_o: 00 gives 4 and 1, 01 gives 2 and 0, 10 gives 2 and 1, 11 gives 1 and 0.
- R4: With the standards bit at 0, codes 00 and 01 give modulus 4 with band_hi_o = 1, and codes 10 and 11 give modulus 2 with band_hi_o = 1.
- R5: In auto mode, a sweep-done strobe that arrives while lock is low and data is present moves the code one step in the order 00, 01, 10, 11, 00. The new code shows one cycle after the strobe edge.
- R6: In auto mode, a sweep-done strobe that arrives while lock is high leaves the code unchanged.
- R7: While data_present_i is 0, strobes leave the code frozen. Once data returns, the next qualifying strobe advances from the frozen code.
- R8: In manual mode, sweep-done strobes are ignored. When the block goes back to auto mode, it uses the code that was held before manual mode.
- R9: rate_code_oe_o follows auto_mode_i with a delay of one clock edge, and it is 1 exactly when auto mode is in effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| auto_mode_i | input | 1 | 1 selects the automatic search, 0 selects manual |
| std_mode_i | input | 1 | Selects the decode table |
| rate_sel_i | input | 2 | Manual rate code, read from the select pins |
| data_present_i | input | 1 | Input data detected |
| lock_i | input | 1 | PLL lock flag |
| sweep_done_i | input | 1 | Strobe: a sweep finished without lock |
| modulus_o | output | 3 | Divider modulus (1, 2 or 4) |
| band_hi_o | output | 1 | 1 selects the high VCO band, 0 the low band |
| rate_code_o | output | 2 | Rate code currently in use |
| rate_code_oe_o | output | 1 | Drive enable for the select pins (auto mode) |

## Verification
The assertions assume that sweep_done_i, lock_i and data_present_i are synchronous to clk and settle before each rising edge. They also assume that a strobe which should count lasts exactly one cycle, because a strobe held high for longer counts once per cycle. The bench changes every input on the falling edge, holds each strobe for a single cycle, and changes the mode and the strobe on different edges, so that the one-edge mode latency is never involved in whether an advance happens.

// File: rtl/rsc_pkg.sv
package rsc_pkg;
  localparam int unsigned CODE_W = 2;
  localparam int unsigned MOD_W  = 3;

  typedef logic [CODE_W-1:0] rate_code_t;

  typedef struct packed {
    logic [MOD_W-1:0] modulus;
    logic             band_hi;
  } rate_cfg_t;

  // Decode a rate code into a divider modulus and a VCO band.
  function automatic rate_cfg_t decode_rate(input logic std_bit, input rate_code_t code);
    rate_cfg_t cfg;
    if (std_bit) begin
      unique case (code)
        2'd0:    cfg = '{modulus: MOD_W'(4), band_hi: 1'b1};
        2'd1:    cfg = '{modulus: MOD_W'(2), band_hi: 1'b0};
        2'd2:    cfg = '{modulus: MOD_W'(2), band_hi: 1'b1};
        default: cfg = '{modulus: MOD_W'(1), band_hi: 1'b0};
      endcase
    end else begin
      cfg.band_hi = 1'b1;
      cfg.modulus = code[1] ? MOD_W'(2) : MOD_W'(4);
    end
    return cfg;
  endfunction

  // Circular successor in the search order.
  function automatic rate_code_t step_code(input rate_code_t code);
    return code + rate_code_t'(1);
  endfunction
endpackage

// File: rtl/rsc_in_reg.sv
module rsc_in_reg #(
  parameter int unsigned W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= d;
  end
endmodule

// File: rtl/rsc_search.sv
module rsc_search
  import rsc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       auto_en,
  input  logic       sweep_done,
  input  logic       lock,
  input  logic       data_present,
  output rate_code_t code,
  output logic       adv_evt,
  output logic       hold_evt
);
  // A strobe counts only in auto mode, with data present and no lock.
  assign adv_evt  = auto_en && sweep_done && !lock && data_present;
  assign hold_evt = sweep_done && !adv_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       code <= '0;
    else if (adv_evt) code <= step_code(code);
  end
endmodule

// File: rtl/rsc_rate_map.sv
module rsc_rate_map
  import rsc_pkg::*;
(
  input  logic             std_bit,
  input  rate_code_t       code,
  output logic [MOD_W-1:0] modulus,
  output logic             band_hi
);
  rate_cfg_t cfg;
  always_comb cfg = decode_rate(std_bit, code);
  assign modulus = cfg.modulus;
  assign band_hi = cfg.band_hi;
endmodule

// File: rtl/rate_search_ctrl.sv
module rate_search_ctrl
  import rsc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              auto_mode_i,
  input  logic              std_mode_i,
  input  logic [CODE_W-1:0] rate_sel_i,
  input  logic              data_present_i,
  input  logic              lock_i,
  input  logic              sweep_done_i,
  output logic [MOD_W-1:0]  modulus_o,
  output logic              band_hi_o,
  output logic [CODE_W-1:0] rate_code_o,
  output logic              rate_code_oe_o
);
  logic       mode_q;
  logic       std_q;
  rate_code_t man_code_q;
  rate_code_t search_code;
  rate_code_t active_code;
  logic       adv_evt;
  logic       hold_evt;

  rsc_in_reg #(.W(1)) u_mode_reg (
    .clk(clk), .rst_n(rst_n), .d(auto_mode_i), .q(mode_q));

  rsc_in_reg #(.W(1)) u_std_reg (
    .clk(clk), .rst_n(rst_n), .d(std_mode_i), .q(std_q));

  rsc_in_reg #(.W(CODE_W)) u_sel_reg (
    .clk(clk), .rst_n(rst_n), .d(rate_sel_i), .q(man_code_q));

  rsc_search u_search (
    .clk(clk), .rst_n(rst_n), .auto_en(mode_q),
    .sweep_done(sweep_done_i), .lock(lock_i), .data_present(data_present_i),
    .code(search_code), .adv_evt(adv_evt), .hold_evt(hold_evt));

  assign active_code = mode_q ? search_code : man_code_q;

  rsc_rate_map u_map (
    .std_bit(std_q), .code(active_code),
    .modulus(modulus_o), .band_hi(band_hi_o));

  assign rate_code_o    = active_code;
  assign rate_code_oe_o = mode_q;
endmodule

// File: rtl/rsc_chk.sv
module rsc_chk
  import rsc_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             auto_mode_i,
  input logic             mode_q,
  input logic             lock_i,
  input logic             data_present_i,
  input logic             adv_evt,
  input logic             hold_evt,
  input rate_code_t       search_code,
  input logic             rate_code_oe_o,
  input logic [MOD_W-1:0] modulus_o
);
  // R5
  step_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adv_evt |=> search_code == rate_code_t'($past(search_code) + 1'b1));

  // R6
  lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q && lock_i) |=> $stable(search_code));

  // R7
  no_data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !data_present_i |=> $stable(search_code));

  // R8
  manual_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold_evt |=> $stable(search_code));

  // R9
  oe_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    auto_mode_i |=> rate_code_oe_o);

  // R9
  oe_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !auto_mode_i |=> !rate_code_oe_o);

  // R3
  always_comb begin
    if (rst_n) begin
      modulus_onehot_chk: assert ($countones(modulus_o) == 1);
    end
  end
endmodule

bind rate_search_ctrl rsc_chk u_chk (
  .clk(clk), .rst_n(rst_n), .auto_mode_i(auto_mode_i), .mode_q(mode_q),
  .lock_i(lock_i), .data_present_i(data_present_i), .adv_evt(adv_evt),
  .hold_evt(hold_evt), .search_code(search_code),
  .rate_code_oe_o(rate_code_oe_o), .modulus_o(modulus_o));

// File: tb/rate_search_ctrl_test.sv
module rate_search_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       auto_mode_i = 1'b0;
  logic       std_mode_i = 1'b0;
  logic [1:0] rate_sel_i = 2'd0;
  logic       data_present_i = 1'b1;
  logic       lock_i = 1'b0;
  logic       sweep_done_i = 1'b0;
  logic [2:0] modulus_o;
  logic       band_hi_o;
  logic [1:0] rate_code_o;
  logic       rate_code_oe_o;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  rate_search_ctrl uut (
    .clk(clk), .rst_n(rst_n), .auto_mode_i(auto_mode_i), .std_mode_i(std_mode_i),
    .rate_sel_i(rate_sel_i), .data_present_i(data_present_i), .lock_i(lock_i),
    .sweep_done_i(sweep_done_i), .modulus_o(modulus_o), .band_hi_o(band_hi_o),
    .rate_code_o(rate_code_o), .rate_code_oe_o(rate_code_oe_o));

  typedef struct packed {
    logic       std;
    logic [1:0] code;
    logic [2:0] modulus;
    logic       band;
  } vec_t;

  localparam vec_t VEC [8] = '{
    '{1'b1, 2'd0, 3'd4, 1'b1}, '{1'b1, 2'd1, 3'd2, 1'b0},
    '{1'b1, 2'd2, 3'd2, 1'b1}, '{1'b1, 2'd3, 3'd1, 1'b0},
    '{1'b0, 2'd0, 3'd4, 1'b1}, '{1'b0, 2'd1, 3'd4, 1'b1},
    '{1'b0, 2'd2, 3'd2, 1'b1}, '{1'b0, 2'd3, 3'd2, 1'b1}};

  // Expected modulus, worked out independently of the table above.
  function automatic logic [2:0] exp_mod(input logic s, input logic [1:0] c);
    if (!s) return (c >= 2'd2) ? 3'd2 : 3'd4;
    if (c == 2'd3) return 3'd1;
    return (c == 2'd0) ? 3'd4 : 3'd2;
  endfunction

  function automatic logic exp_band(input logic s, input logic [1:0] c);
    return !s || !c[0];
  endfunction

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic strobe;
    sweep_done_i = 1'b1;
    tick();
    sweep_done_i = 1'b0;
  endtask

  task automatic check_cfg(input string req, input logic s, input logic [1:0] c);
    check(req, rate_code_o, c);
    check(req, modulus_o, exp_mod(s, c));
    check(req, band_hi_o, exp_band(s, c));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    // R1 reset state
    check("R1", rate_code_o, 0);
    check("R1", modulus_o, 4);
    check("R1", band_hi_o, 1);
    check("R1", rate_code_oe_o, 0);
    rst_n = 1'b1;
    tick();

    // R2 R3 R4 manual decode table
    for (int i = 0; i < 8; i++) begin
      std_mode_i = VEC[i].std;
      rate_sel_i = VEC[i].code;
      tick();
      check("R2", rate_code_o, VEC[i].code);
      check("R2", rate_code_oe_o, 0);
      check(VEC[i].std ? "R3" : "R4", modulus_o, VEC[i].modulus);
      check(VEC[i].std ? "R3" : "R4", band_hi_o, VEC[i].band);
    end

    // R8 strobes in manual mode are ignored; the search code stays 00
    rate_sel_i = 2'd3;
    std_mode_i = 1'b1;
    tick();
    strobe();
    strobe();
    check("R8", rate_code_o, 3);

    // R9 the mode switches after one edge
    auto_mode_i = 1'b1;
    check("R9", rate_code_oe_o, 0);
    tick();
    check("R9", rate_code_oe_o, 1);
    check_cfg("R8", 1'b1, 2'd0);

    // R5 circular advance with standards bit 1
    for (int k = 1; k <= 4; k++) begin
      strobe();
      check_cfg("R5", 1'b1, 2'(k));
    end

    // R6 no advance while locked
    strobe();
    check_cfg("R5", 1'b1, 2'd1);
    lock_i = 1'b1;
    strobe();
    strobe();
    check_cfg("R6", 1'b1, 2'd1);
    lock_i = 1'b0;

    // R7 freeze without data, then resume from the frozen code
    data_present_i = 1'b0;
    strobe();
    strobe();
    check_cfg("R7", 1'b1, 2'd1);
    data_present_i = 1'b1;
    tick();
    check_cfg("R7", 1'b1, 2'd1);
    strobe();
    check_cfg("R7", 1'b1, 2'd2);

    // R4 auto mode with standards bit 0
    std_mode_i = 1'b0;
    tick();
    check_cfg("R4", 1'b0, 2'd2);
    strobe();
    check_cfg("R4", 1'b0, 2'd3);

    // R8 leave auto, strobe, return: code kept
    auto_mode_i = 1'b0;
    rate_sel_i = 2'd0;
    tick();
    check("R9", rate_code_oe_o, 0);
    strobe();
    auto_mode_i = 1'b1;
    tick();
    check_cfg("R8", 1'b0, 2'd3);

    // R1 reset in the middle of a run
    rst_n = 1'b0;
    tick();
    check("R1", rate_code_o, 0);
    check("R1", rate_code_oe_o, 0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule